// File: doc/BRIEF.md
# Logical Address Window Decoder

This block decides, for a bus bridge, whether an 8-bit logical address crosses to the other side. A 16-bit window register holds two bounds. An upper bound sits in bits 15:8 and a lower bound in bits 7:0. Two independent decode paths test an address against the bounds. The inbound path handles traffic from the remote side toward the local side, and the outbound path handles traffic from the local side toward the remote side. Each path produces a registered forward flag.

The two bounds set the shape of the window:

- When the upper bound exceeds the lower bound, the half-open interval between them is the inbound window. The outbound path takes its complement.
- When the bounds are swapped, the half-open interval from upper to lower is the outbound window. Inbound becomes the wrapped complement.
- Equal bounds are special. A common value of zero disables both paths. A common value with the top bit set sends every local address out. Any other common value pulls every remote address in.

The register is loaded through a small synchronous port with a write strobe and one byte enable per bound. It is read back with one cycle of latency.

Top module: `lawin_decoder`

## Requirements
- R1: After a synchronous active-high reset the register holds 0x0000, the read data is 0x0000 and both forward flags are low.
- R2: A write with `reg_we` high loads `reg_wdata[15:8]` into the upper bound only when `reg_be[1]` is set, and `reg_wdata[7:0]` into the lower bound only when `reg_be[0]` is set. A bound whose enable is clear keeps its value.
- R3: `reg_rdata` shows the register contents as they stood at the previous clock edge, so a write becomes visible on the read port one cycle after the edge that stores it.
- R4: When upper > lower, `in_fwd` is set exactly for addresses with lower ≤ addr < upper, and `out_fwd` is set exactly for addresses with addr ≥ upper or addr < lower.
- R5: When lower > upper, `out_fwd` is set exactly for addresses with upper ≤ addr < lower, and `in_fwd` is set exactly for addresses with addr ≥ lower or addr < upper.
- R6: When both bounds are 0x00, neither flag is set for any address.
- R7: When the bounds are equal and their value lies in 0x80–0xFF, `out_fwd` is set for every address and `in_fwd` for none.
- R8: When the bounds are equal and their value lies in 0x01–0x7F, `in_fwd` is set for every address and `out_fwd` for none.
- R9: Each flag reflects the address sampled at the previous clock edge. A register write stored at one edge governs the decode from the following edge onward; the decode captured at the storing edge still uses the old bounds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables: bit 1 upper bound, bit 0 lower bound |
| reg_wdata | input | 16 | Write data: upper bound in 15:8, lower bound in 7:0 |
| reg_rdata | output | 16 | Registered read-back of the window register |
| in_addr | input | 8 | Address arriving from the remote side |
| in_fwd | output | 1 | Registered flag: forward `in_addr` to the local side |
| out_addr | input | 8 | Address arriving from the local side |
| out_fwd | output | 1 | Registered flag: forward `out_addr` to the remote side |

## Verification
On every cycle, the assertions check the following:

- A bound whose byte enable is clear stays unchanged.
- A zero window keeps both flags quiet.
- Each equal-bound setting drives one flag high and the other low.
- When the two paths see the same address under a proper or swapped window, exactly one flag is set.

The assertions cannot tell whether an interval edge sits at the right address. The bench shows this by sweeping all 256 addresses for a set of bound pairs. The pairs cover normal and swapped windows, adjacent bounds and every equal-bound class. The bench also covers the one-cycle latencies of the read port and of a newly written window.

// File: rtl/lawin_pkg.sv
package lawin_pkg;

    parameter int unsigned LA_W   = 8;
    localparam int unsigned N_HALF = 2;
    localparam int unsigned REG_W  = LA_W * N_HALF;

    typedef logic [LA_W-1:0] la_t;

    typedef struct packed {
        la_t hi;
        la_t lo;
    } win_t;

    typedef enum logic [2:0] {
        WM_OFF     = 3'd0,
        WM_SPAN    = 3'd1,
        WM_WRAP    = 3'd2,
        WM_ALL_OUT = 3'd3,
        WM_ALL_IN  = 3'd4
    } wmode_e;

    function automatic wmode_e classify(input win_t w);
        wmode_e m;
        if (w.hi == w.lo) begin
            if (w.hi == '0)
                m = WM_OFF;
            else if (w.hi[LA_W-1])
                m = WM_ALL_OUT;
            else
                m = WM_ALL_IN;
        end else if (w.hi > w.lo) begin
            m = WM_SPAN;
        end else begin
            m = WM_WRAP;
        end
        return m;
    endfunction

    function automatic logic half_open(input la_t a, input la_t base, input la_t limit);
        return (a >= base) && (a < limit);
    endfunction

endpackage

// File: rtl/lawin_reg.sv
module lawin_reg
    import lawin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [N_HALF-1:0] be,
    input  logic [REG_W-1:0]  wdata,
    output win_t              win,
    output logic [REG_W-1:0]  rdata
);

    logic [N_HALF-1:0][LA_W-1:0] half_q;
    logic [REG_W-1:0]            rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= '0;
            rd_q   <= '0;
        end else begin
            for (int h = 0; h < N_HALF; h++) begin
                if (we && be[h])
                    half_q[h] <= wdata[h*LA_W +: LA_W];
            end
            rd_q <= half_q;
        end
    end

    assign win   = win_t'(half_q);
    assign rdata = rd_q;

    for (genvar g = 0; g < N_HALF; g++) begin : g_hold_chk
        AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(we && be[g]) |=> $stable(half_q[g])) // R2
            else $error("bound %0d changed without its enable", g);
    end

endmodule

// File: rtl/lawin_mode.sv
module lawin_mode
    import lawin_pkg::*;
(
    input  win_t   win,
    output wmode_e mode
);

    always_comb begin
        mode = classify(win);
    end

endmodule

// File: rtl/lawin_path.sv
module lawin_path
    import lawin_pkg::*;
#(
    parameter bit INBOUND = 1'b1
)(
    input  logic   clk,
    input  logic   rst,
    input  win_t   win,
    input  wmode_e mode,
    input  la_t    addr,
    output logic   fwd
);

    logic span_in;
    logic wrap_in;
    logic hit;

    assign span_in = half_open(addr, win.lo, win.hi);
    assign wrap_in = half_open(addr, win.hi, win.lo);

    if (INBOUND) begin : g_in
        always_comb begin
            unique case (mode)
                WM_SPAN:   hit = span_in;
                WM_WRAP:   hit = !wrap_in;
                WM_ALL_IN: hit = 1'b1;
                default:   hit = 1'b0;
            endcase
        end
    end else begin : g_out
        always_comb begin
            unique case (mode)
                WM_SPAN:    hit = !span_in;
                WM_WRAP:    hit = wrap_in;
                WM_ALL_OUT: hit = 1'b1;
                default:    hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            fwd <= 1'b0;
        else
            fwd <= hit;
    end

endmodule

// File: rtl/lawin_decoder.sv
module lawin_decoder
    import lawin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_be,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [7:0]       in_addr,
    output logic             in_fwd,
    input  logic [7:0]       out_addr,
    output logic             out_fwd
);

    win_t   win;
    wmode_e mode;

    lawin_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .be    (reg_be),
        .wdata (reg_wdata),
        .win   (win),
        .rdata (reg_rdata)
    );

    lawin_mode u_mode (
        .win  (win),
        .mode (mode)
    );

    lawin_path #(.INBOUND(1'b1)) u_in (
        .clk  (clk),
        .rst  (rst),
        .win  (win),
        .mode (mode),
        .addr (in_addr),
        .fwd  (in_fwd)
    );

    lawin_path #(.INBOUND(1'b0)) u_out (
        .clk  (clk),
        .rst  (rst),
        .win  (win),
        .mode (mode),
        .addr (out_addr),
        .fwd  (out_fwd)
    );

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == WM_OFF) |=> (!in_fwd && !out_fwd)) // R6
        else $error("flag raised while window disabled");

    AST_SPLIT_ONE: assert property (@(posedge clk) disable iff (rst)
        ((mode == WM_SPAN || mode == WM_WRAP) && in_addr == out_addr) |=> (in_fwd != out_fwd)) // R4
        else $error("same address forwarded both or neither way");

    AST_EQ_ALL_OUT: assert property (@(posedge clk) disable iff (rst)
        (mode == WM_ALL_OUT) |=> (out_fwd && !in_fwd)) // R7
        else $error("all-out setting violated");

    AST_EQ_ALL_IN: assert property (@(posedge clk) disable iff (rst)
        (mode == WM_ALL_IN) |=> (in_fwd && !out_fwd)) // R8
        else $error("all-in setting violated");

endmodule

// File: tb/sim_lawin_decoder.sv
`timescale 1ns/1ps
module sim_lawin_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  in_addr = '0;
    logic        in_fwd;
    logic [7:0]  out_addr = '0;
    logic        out_fwd;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    lawin_decoder u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_addr(in_addr), .in_fwd(in_fwd),
        .out_addr(out_addr), .out_fwd(out_fwd)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_be = 2'b00;
    endtask

    function automatic logic exp_in(input logic [7:0] hi, input logic [7:0] lo, input int a);
        if (hi == lo) return (hi != 0) && (hi < 8'h80);
        if (hi > lo)  return (a >= lo) && (a < hi);
        return (a >= lo) || (a < hi);
    endfunction

    function automatic logic exp_out(input logic [7:0] hi, input logic [7:0] lo, input int a);
        if (hi == lo) return hi >= 8'h80;
        if (hi > lo)  return (a >= hi) || (a < lo);
        return (a >= hi) && (a < lo);
    endfunction

    task automatic sweep(input logic [7:0] hi, input logic [7:0] lo);
        string tag;
        if (hi == lo)     tag = (hi == 0) ? "R6" : (hi >= 8'h80 ? "R7" : "R8");
        else if (hi > lo) tag = "R4";
        else              tag = "R5";
        wr(2'b11, {hi, lo});
        for (int a = 0; a < 256; a++) begin
            int b;
            b = a ^ 8'h5A;
            in_addr  = 8'(a);
            out_addr = 8'(b);
            @(negedge clk);
            chk($sformatf("%s in hi=%h lo=%h a=%h", tag, hi, lo, a), 16'(in_fwd), 16'(exp_in(hi, lo, a)));
            chk($sformatf("%s out hi=%h lo=%h a=%h", tag, hi, lo, b), 16'(out_fwd), 16'(exp_out(hi, lo, b)));
        end
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rdata after reset", reg_rdata, 16'h0000);
        chk("R1 in_fwd after reset", 16'(in_fwd), 16'h0);
        chk("R1 out_fwd after reset", 16'(out_fwd), 16'h0);

        wr(2'b01, 16'hAA55);
        @(negedge clk);
        chk("R2 lower only", reg_rdata, 16'h0055);
        wr(2'b10, 16'h3C99);
        @(negedge clk);
        chk("R2 upper only", reg_rdata, 16'h3C55);
        wr(2'b00, 16'hFFFF);
        @(negedge clk);
        chk("R2 no enable", reg_rdata, 16'h3C55);

        wr(2'b11, 16'h0000);
        @(negedge clk);
        in_addr = 8'h30; out_addr = 8'h30;
        reg_we = 1'b1; reg_be = 2'b11; reg_wdata = 16'h4020;
        @(negedge clk);
        reg_we = 1'b0; reg_be = 2'b00;
        chk("R9 old window at storing edge", 16'(in_fwd), 16'h0);
        chk("R3 rdata one cycle behind", reg_rdata, 16'h0000);
        @(negedge clk);
        chk("R9 new window next edge", 16'(in_fwd), 16'h1);
        chk("R3 rdata shows write", reg_rdata, 16'h4020);
        in_addr = 8'h50;
        #1;
        chk("R9 flag holds until edge", 16'(in_fwd), 16'h1);
        @(negedge clk);
        chk("R9 flag follows address", 16'(in_fwd), 16'h0);

        sweep(8'h00, 8'h00);
        sweep(8'h80, 8'h80);
        sweep(8'hFF, 8'hFF);
        sweep(8'h7F, 8'h7F);
        sweep(8'h01, 8'h01);
        sweep(8'h40, 8'h20);
        sweep(8'h20, 8'h40);
        sweep(8'hFF, 8'h00);
        sweep(8'h00, 8'hFF);
        sweep(8'h81, 8'h80);
        sweep(8'h10, 8'hF0);
        sweep(8'hC0, 8'h3F);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule